// File: doc/BRIEF.md
# Multi-Bank Clock Divider Network

This block sits behind a frequency synthesizer and turns one fast source clock into three banks of divided clocks and one feedback clock. The source is normally the oscillator clock. A bypass input swaps in one of two reference clocks, and a select bit chooses which one. A shared prescaler runs at either ÷2 or ÷4. Each bank then applies its own post-divider, chosen by one select bit per bank. The feedback output uses a 2-bit code. The overall ratios include ÷12, ÷24 and ÷48, and every output keeps an exact 50% duty cycle.

An active-low stop input parks the three banks low. The stop request is synchronized to the source clock. It is applied or lifted only at an output transition, so no bank ever produces a shortened high pulse. The feedback clock keeps running while the banks are stopped.

An active-low master reset floats every output at once. It also clears all divider state. Reset is released synchronously, so all dividers restart together and their first rising edges coincide. A change to a bank or feedback select is taken up only at the end of a full output period.

Top module: `cdn_divider_net`

## Requirements
- R1: When `pll_on` is 0, the dividers run from `ref_clk0` if `ref_sel` is 0 and from `ref_clk1` if `ref_sel` is 1. When `pll_on` is 1, they run from `vco_clk`.
- R2: The prescale factor P is 2 when `vco_sel` is 0 and 4 when it is 1. Banks A and B divide the source by P·2 when their select bit is 0 and by P·4 when it is 1, giving ÷4/÷8 or ÷8/÷16.
- R3: Bank C divides the source by P·4 when `sel_c` is 0 and by P·6 when it is 1, giving ÷8, ÷12, ÷16 or ÷24.
- R4: `fb_out` divides the source by P·4, P·8, P·6 or P·12 for `sel_fb` values 0, 1, 2 and 3. The full set of ratios is ÷8, ÷16, ÷12, ÷24, ÷16, ÷32, ÷24 and ÷48.
- R5: In steady state, every output is high for exactly half of its period.
- R6: All pins of one bank carry the same waveform at all times.
- R7: While `stop_n` is held low, the outputs of banks A, B and C stay low, and `fb_out` keeps toggling at its selected ratio.
- R8: Asserting or releasing `stop_n` at any moment never produces a bank high pulse shorter than the bank's nominal half period.
- R9: While `mr_n` is 0, every output is high-impedance.
- R10: After `mr_n` returns to 1, the first rising edges of banks A, B, C and the feedback output fall on the same source edge.
- R11: A change to a bank select while running is taken up at a period boundary. No high or low phase around the change is shorter than the smaller half period or longer than the larger one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator clock, the source in normal mode |
| ref_clk0 | input | 1 | Reference clock 0 |
| ref_clk1 | input | 1 | Reference clock 1 |
| ref_sel | input | 1 | Reference choice: 0 picks `ref_clk0`, 1 picks `ref_clk1` |
| pll_on | input | 1 | 1 runs the dividers from `vco_clk`; 0 selects bypass |
| vco_sel | input | 1 | Shared prescale: 0 gives ÷2, 1 gives ÷4 |
| sel_a | input | 1 | Bank A post-divider select |
| sel_b | input | 1 | Bank B post-divider select |
| sel_c | input | 1 | Bank C post-divider select |
| sel_fb | input | 2 | Feedback post-divider code |
| stop_n | input | 1 | Active-low stop for banks A, B and C |
| mr_n | input | 1 | Active-low master reset and output float |
| q_a | output | A_PINS | Bank A clock outputs |
| q_b | output | B_PINS | Bank B clock outputs |
| q_c | output | C_PINS | Bank C clock outputs |
| fb_out | output | 1 | Feedback clock output |

## Verification
The bench measures every high and low run across stop assertion and release at several phases. A stop gate that changed without waiting for an output transition would show a sliver-wide pulse. It switches a bank select back and forth at staggered moments. A divider that picked up a new half-period mid-count would overshoot its terminal value and leave a low phase many ticks too long. After each reset release it compares the first rising edge of every bank and of the feedback clock. Counters that were not cleared, or a reset released per divider, would show staggered edges. With the outputs pulled high externally, a reset that drove the pins low instead of floating them reads as 0.

// File: rtl/cdn_pkg.sv
package cdn_pkg;

   // Widest half-period, in prescaled ticks, that any divider needs (6 for the /12 post-divide).
   localparam int unsigned HALF_MAX = 6;
   localparam int unsigned HALF_W   = $clog2(HALF_MAX + 1);

   typedef logic [HALF_W-1:0] half_t;

   // Banks A and B: post-divide 2 or 4.
   function automatic half_t ab_half(input logic fsel);
      return fsel ? half_t'(2) : half_t'(1);
   endfunction

   // Bank C: post-divide 4 or 6.
   function automatic half_t c_half(input logic fsel);
      return fsel ? half_t'(3) : half_t'(2);
   endfunction

   // Feedback: post-divide 4, 8, 6 or 12.
   function automatic half_t fb_half(input logic [1:0] code);
      half_t h;
      case (code)
         2'd0:    h = half_t'(2);
         2'd1:    h = half_t'(4);
         2'd2:    h = half_t'(3);
         default: h = half_t'(6);
      endcase
      return h;
   endfunction

endpackage

// File: rtl/cdn_src_mux.sv
module cdn_src_mux (
   input  logic vco_clk,
   input  logic ref_clk0,
   input  logic ref_clk1,
   input  logic ref_sel,
   input  logic pll_on,
   output logic src_clk
);

   logic ref_clk;

   assign ref_clk = ref_sel ? ref_clk1 : ref_clk0;
   assign src_clk = pll_on ? vco_clk : ref_clk;

endmodule

// File: rtl/cdn_sync.sv
module cdn_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cdn_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shf;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) shf <= {STAGES{RST_VAL}};
      else         shf <= {shf[STAGES-2:0], d};
   end

   assign q = shf[STAGES-1];

endmodule

// File: rtl/cdn_prescale.sv
module cdn_prescale #(
   parameter int unsigned LO = 2,
   parameter int unsigned HI = 4
) (
   input  logic clk,
   input  logic run,
   input  logic quad,
   output logic tick
);

   localparam int unsigned PW = (HI > 2) ? $clog2(HI) : 1;

   if (LO < 1 || HI < LO) begin : g_bad_ratio
      $error("cdn_prescale: need 1 <= LO <= HI");
   end

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] last_q;
   logic          term;

   assign term = (cnt_q == last_q);

   // The ratio is taken up only at a terminal count, or freely while held in reset.
   always_ff @(posedge clk) begin
      if (!run || term) last_q <= quad ? PW'(HI - 1) : PW'(LO - 1);
   end

   always_ff @(posedge clk or negedge run) begin
      if (!run)      cnt_q <= '0;
      else if (term) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run & term;

endmodule

// File: rtl/cdn_divider.sv
module cdn_divider #(
   parameter int unsigned HW    = 3,
   parameter bit          GATED = 1'b1
) (
   input  logic          clk,
   input  logic          run,
   input  logic          tick,
   input  logic [HW-1:0] half_sel,
   input  logic          stop_ok,
   output logic          clk_out
);

   localparam int unsigned CW = HW + 1;

   if (HW < 1) begin : g_bad_width
      $error("cdn_divider: HW must be at least 1");
   end

   logic [CW-1:0] pc_q;
   logic [HW-1:0] h_q;
   logic          out_q;
   logic          term;
   logic          out_nx;

   assign term   = (pc_q == ({h_q, 1'b0} - CW'(1)));
   assign out_nx = (pc_q < {1'b0, h_q});

   // A new half-period is adopted only at the end of a full output period.
   always_ff @(posedge clk) begin
      if (!run || (tick && term)) h_q <= half_sel;
   end

   always_ff @(posedge clk or negedge run) begin
      if (!run) begin
         pc_q  <= '0;
         out_q <= 1'b0;
      end else if (tick) begin
         pc_q  <= term ? '0 : pc_q + 1'b1;
         out_q <= out_nx;
      end
   end

   if (GATED) begin : g_gate
      logic en_q;
      // The gate moves only on the tick where the raw output itself changes.
      always_ff @(posedge clk or negedge run) begin
         if (!run)                           en_q <= 1'b0;
         else if (tick && (out_nx != out_q)) en_q <= stop_ok;
      end
      assign clk_out = out_q & en_q;
   end else begin : g_free
      logic unused_stop;
      assign unused_stop = stop_ok;
      assign clk_out     = out_q;
   end

endmodule

// File: rtl/cdn_divider_net.sv
module cdn_divider_net
   import cdn_pkg::*;
#(
   parameter int unsigned A_PINS      = 5,
   parameter int unsigned B_PINS      = 5,
   parameter int unsigned C_PINS      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PRE_LO      = 2,
   parameter int unsigned PRE_HI      = 4
) (
   input  logic              vco_clk,
   input  logic              ref_clk0,
   input  logic              ref_clk1,
   input  logic              ref_sel,
   input  logic              pll_on,
   input  logic              vco_sel,
   input  logic              sel_a,
   input  logic              sel_b,
   input  logic              sel_c,
   input  logic [1:0]        sel_fb,
   input  logic              stop_n,
   input  logic              mr_n,
   output logic [A_PINS-1:0] q_a,
   output logic [B_PINS-1:0] q_b,
   output logic [C_PINS-1:0] q_c,
   output logic              fb_out
);

   localparam int unsigned NBANK = 3;
   localparam int unsigned C_IDX = 2;

   if (A_PINS < 1 || B_PINS < 1 || C_PINS < 1) begin : g_bad_pins
      $error("cdn_divider_net: every bank needs at least one pin");
   end

   logic             src_clk;
   logic             run;
   logic             stop_ok;
   logic             tick;
   logic             fb_int;
   logic [NBANK-1:0] bank_clk;
   logic [NBANK-1:0] bank_fsel;
   half_t            bank_half [NBANK];

   cdn_src_mux u_mux (
      .vco_clk  (vco_clk),
      .ref_clk0 (ref_clk0),
      .ref_clk1 (ref_clk1),
      .ref_sel  (ref_sel),
      .pll_on   (pll_on),
      .src_clk  (src_clk)
   );

   // Reset: asserted at once, released on a source edge.
   cdn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
      .clk    (src_clk),
      .arst_n (mr_n),
      .d      (1'b1),
      .q      (run)
   );

   cdn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stop_sync (
      .clk    (src_clk),
      .arst_n (mr_n),
      .d      (stop_n),
      .q      (stop_ok)
   );

   cdn_prescale #(.LO(PRE_LO), .HI(PRE_HI)) u_pre (
      .clk  (src_clk),
      .run  (run),
      .quad (vco_sel),
      .tick (tick)
   );

   assign bank_fsel = {sel_c, sel_b, sel_a};

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bank_half[b] = (b == C_IDX) ? c_half(bank_fsel[b]) : ab_half(bank_fsel[b]);

      cdn_divider #(.HW(HALF_W), .GATED(1'b1)) u_div (
         .clk      (src_clk),
         .run      (run),
         .tick     (tick),
         .half_sel (bank_half[b]),
         .stop_ok  (stop_ok),
         .clk_out  (bank_clk[b])
      );
   end

   cdn_divider #(.HW(HALF_W), .GATED(1'b0)) u_fb (
      .clk      (src_clk),
      .run      (run),
      .tick     (tick),
      .half_sel (fb_half(sel_fb)),
      .stop_ok  (stop_ok),
      .clk_out  (fb_int)
   );

   assign q_a    = mr_n ? {A_PINS{bank_clk[0]}} : {A_PINS{1'bz}};
   assign q_b    = mr_n ? {B_PINS{bank_clk[1]}} : {B_PINS{1'bz}};
   assign q_c    = mr_n ? {C_PINS{bank_clk[2]}} : {C_PINS{1'bz}};
   assign fb_out = mr_n ? fb_int : 1'bz;

endmodule

// File: rtl/cdn_checker.sv
module cdn_checker #(
   parameter int unsigned NBANK   = 3,
   parameter int unsigned MAX_GAP = 24
) (
   input logic             src_clk,
   input logic             run,
   input logic             stop_ok,
   input logic             tick,
   input logic [NBANK-1:0] bank_clk,
   input logic             fb_int
);

   localparam int unsigned GW = $clog2(MAX_GAP + 2) + 1;

   logic [GW-1:0] gap_q;
   logic          fb_prev;

   always_ff @(posedge src_clk or negedge run) begin
      if (!run) begin
         gap_q   <= '0;
         fb_prev <= 1'b0;
      end else begin
         fb_prev <= fb_int;
         if (fb_int != fb_prev)      gap_q <= '0;
         else if (gap_q != '1)       gap_q <= gap_q + 1'b1;
      end
   end

   // R7: the feedback clock never stalls, stop or not.
   a_r7_fb_alive: assert property (@(posedge src_clk) disable iff (!run)
      gap_q <= GW'(MAX_GAP));

   // R4: the feedback output changes only after a prescale tick.
   a_r4_fb_on_tick: assert property (@(posedge src_clk) disable iff (!run)
      !$stable(fb_int) |-> $past(tick));

   for (genvar b = 0; b < NBANK; b++) begin : g_bank_chk
      // R7: a bank can rise only when the synchronized stop allowed it.
      a_r7_no_rise_stopped: assert property (@(posedge src_clk) disable iff (!run)
         $rose(bank_clk[b]) |-> $past(stop_ok));

      // R8: bank edges happen only on ticks, so gating never cuts a phase short.
      a_r8_edge_on_tick: assert property (@(posedge src_clk) disable iff (!run)
         !$stable(bank_clk[b]) |-> $past(tick));
   end

endmodule

bind cdn_divider_net cdn_checker #(.NBANK(3), .MAX_GAP(PRE_HI * 6)) u_chk (
   .src_clk  (src_clk),
   .run      (run),
   .stop_ok  (stop_ok),
   .tick     (tick),
   .bank_clk (bank_clk),
   .fb_int   (fb_int)
);

// File: tb/cdn_divider_net_bench.sv
module cdn_divider_net_bench;

   localparam int NOUT = 15;
   localparam int IA = 0, IB = 5, IC = 10, IF = 14;
   // {vco_sel, sel_a, sel_b, sel_c, sel_fb[1:0]}, then full ratios for A, B, C, FB.
   localparam logic [29:0] VEC [7] = '{
      {6'b0_0_0_0_00, 6'd4,  6'd4,  6'd8,  6'd8 },
      {6'b0_1_0_1_01, 6'd8,  6'd4,  6'd12, 6'd16},
      {6'b0_0_1_0_10, 6'd4,  6'd8,  6'd8,  6'd12},
      {6'b0_1_1_1_11, 6'd8,  6'd8,  6'd12, 6'd24},
      {6'b1_0_1_0_10, 6'd8,  6'd16, 6'd16, 6'd24},
      {6'b1_1_0_1_11, 6'd16, 6'd8,  6'd24, 6'd48},
      {6'b1_0_0_1_00, 6'd8,  6'd8,  6'd24, 6'd16}
   };

   logic vco_clk = 1'b0, ref_clk0 = 1'b0, ref_clk1 = 1'b0;
   logic ref_sel = 1'b0, pll_on = 1'b1, vco_sel = 1'b0;
   logic sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
   logic [1:0] sel_fb = 2'd0;
   logic stop_n = 1'b1, mr_n = 1'b0;
   wire [NOUT-1:0] allq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   int m_hmin [NOUT], m_hmax [NOUT], m_lmin [NOUT], m_lmax [NOUT], m_nr [NOUT];

   for (genvar i = 0; i < NOUT; i++) begin : g_pu
      pullup (allq[i]);
   end

   cdn_divider_net u_cdn_divider_net (
      .vco_clk (vco_clk), .ref_clk0 (ref_clk0), .ref_clk1 (ref_clk1),
      .ref_sel (ref_sel), .pll_on (pll_on), .vco_sel (vco_sel),
      .sel_a (sel_a), .sel_b (sel_b), .sel_c (sel_c), .sel_fb (sel_fb),
      .stop_n (stop_n), .mr_n (mr_n),
      .q_a (allq[4:0]), .q_b (allq[9:5]), .q_c (allq[13:10]), .fb_out (allq[14])
   );

   initial forever #4  vco_clk  = ~vco_clk;   // 125 MHz, 8 units per cycle
   initial forever #6  ref_clk0 = ~ref_clk0;
   initial forever #10 ref_clk1 = ~ref_clk1;

   task automatic chk(input bit ok, input string tag, input int got, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
      end
   endtask

   task automatic set_cfg(input logic [5:0] c);
      {vco_sel, sel_a, sel_b, sel_c, sel_fb} = c;
   endtask

   // Sampling at odd times while every clock edge lands on an even time.
   task automatic measure(input int idx, input int win);
      int lr = -1, lf = -1, now;
      logic pv, v;
      m_hmin[idx] = 1 << 30; m_hmax[idx] = 0;
      m_lmin[idx] = 1 << 30; m_lmax[idx] = 0; m_nr[idx] = 0;
      pv = (allq[idx] === 1'b1);
      for (int s = 0; s < win / 2; s++) begin
         #2;
         now = int'($time);
         v = (allq[idx] === 1'b1);
         if (v && !pv) begin
            m_nr[idx]++;
            if (lf >= 0) begin
               if (now - lf < m_lmin[idx]) m_lmin[idx] = now - lf;
               if (now - lf > m_lmax[idx]) m_lmax[idx] = now - lf;
            end
            lr = now;
         end
         if (!v && pv) begin
            if (lr >= 0) begin
               if (now - lr < m_hmin[idx]) m_hmin[idx] = now - lr;
               if (now - lr > m_hmax[idx]) m_hmax[idx] = now - lr;
            end
            lf = now;
         end
         pv = v;
      end
   endtask

   task automatic measure_four(input int win);
      fork
         measure(IA, win);
         measure(IB, win);
         measure(IC, win);
         measure(IF, win);
      join
   endtask

   task automatic check_half(input int idx, input int exp, input string tag);
      chk(m_hmin[idx] == exp && m_hmax[idx] == exp, {tag, " high"}, m_hmax[idx], exp);
      chk(m_lmin[idx] == exp && m_lmax[idx] == exp, {tag, " low R5"}, m_lmax[idx], exp);
   endtask

   // Releases reset and checks that all first rising edges coincide (R10).
   task automatic release_and_align();
      int ids [4] = '{IA, IB, IC, IF};
      int tf [4];
      logic pv [4];
      logic v;
      mr_n = 1'b1;
      for (int j = 0; j < 4; j++) begin tf[j] = -1; pv[j] = 1'b0; end
      for (int s = 0; s < 300; s++) begin
         #2;
         for (int j = 0; j < 4; j++) begin
            v = (allq[ids[j]] === 1'b1);
            if (v && !pv[j] && tf[j] < 0) tf[j] = int'($time);
            pv[j] = v;
         end
      end
      chk(tf[0] >= 0, "R10 bank A rose after release", tf[0], 0);
      for (int j = 1; j < 4; j++)
         chk(tf[j] == tf[0], "R10 first rise aligned", tf[j], tf[0]);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired got=0 exp=1");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [5:0] cfg;
      #1;
      set_cfg(VEC[3][29:24]);
      #40;
      // R9: every output floats while in reset (pull-ups read 1).
      chk(allq === {NOUT{1'b1}}, "R9 outputs float in reset", int'(allq), 32'h7fff);
      release_and_align();

      // R2, R3, R4, R5: ratio table walk.
      for (int i = 0; i < 7; i++) begin
         cfg = VEC[i][29:24];
         set_cfg(cfg);
         #1000;
         measure_four(1200);
         check_half(IA, int'(VEC[i][23:18]) * 4, "R2 bank A");
         check_half(IB, int'(VEC[i][17:12]) * 4, "R2 bank B");
         check_half(IC, int'(VEC[i][11:6])  * 4, "R3 bank C");
         check_half(IF, int'(VEC[i][5:0])   * 4, "R4 feedback");
      end

      // R6: every pin of a bank matches its first pin.
      begin
         int mism = 0;
         for (int s = 0; s < 200; s++) begin
            #2;
            if (allq[4:0] != {5{allq[0]}} || allq[9:5] != {5{allq[5]}} ||
                allq[13:10] != {4{allq[10]}}) mism++;
         end
         chk(mism == 0, "R6 bank pins identical", mism, 0);
      end

      // R11: bank A select flipped at staggered moments (half 16 or 32).
      set_cfg(VEC[0][29:24]);
      #1000;
      for (int k = 0; k < 4; k++) begin
         fork
            measure(IA, 800);
            begin #(100 + 6 * k); sel_a = 1'b1; #200; sel_a = 1'b0; end
         join
         chk(m_hmin[IA] >= 16 && m_hmax[IA] <= 32, "R11 high phase bounded", m_hmax[IA], 32);
         chk(m_lmin[IA] >= 16 && m_lmax[IA] <= 32, "R11 low phase bounded", m_lmax[IA], 32);
      end

      // R8: stop asserted and released at several phases; no short pulses.
      #400;
      for (int k = 0; k < 3; k++) begin
         fork
            measure(IA, 1600);
            begin #(200 + 6 * k); stop_n = 1'b0; #600; stop_n = 1'b1; end
         join
         chk(m_hmin[IA] == 16 && m_hmax[IA] == 16, "R8 full-width highs", m_hmin[IA], 16);
         chk(m_lmin[IA] >= 16 && m_lmax[IA] >= 500, "R8 parked low gap", m_lmax[IA], 500);
      end

      // R7: held stop parks banks low; feedback keeps its ratio (half 32).
      stop_n = 1'b0;
      #200;
      measure_four(400);
      chk(m_nr[IA] + m_nr[IB] + m_nr[IC] == 0, "R7 banks without edges",
          m_nr[IA] + m_nr[IB] + m_nr[IC], 0);
      chk(allq[13:0] == 14'd0, "R7 banks driven low", int'(allq[13:0]), 0);
      chk(m_hmin[IF] == 32 && m_hmax[IF] == 32 && m_nr[IF] > 0, "R7 feedback running",
          m_hmax[IF], 32);
      stop_n = 1'b1;

      // R1: bypass onto ref_clk0 (period 12) then ref_clk1 (period 20), ratios 4 and 8.
      pll_on = 1'b0; ref_sel = 1'b0;
      #1000;
      measure_four(1200);
      chk(m_hmin[IA] == 24 && m_hmax[IA] == 24, "R1 bypass ref0 bank A", m_hmax[IA], 24);
      chk(m_hmin[IF] == 48 && m_hmax[IF] == 48, "R1 bypass ref0 feedback", m_hmax[IF], 48);
      ref_sel = 1'b1;
      #1000;
      measure_four(1600);
      chk(m_hmin[IA] == 40 && m_hmax[IA] == 40, "R1 bypass ref1 bank A", m_hmax[IA], 40);
      chk(m_hmin[IF] == 80 && m_hmax[IF] == 80, "R1 bypass ref1 feedback", m_hmax[IF], 80);
      pll_on = 1'b1;

      // R9 and R10: reset in mid-run clears all dividers and realigns them.
      set_cfg(VEC[5][29:24]);
      #1000;
      mr_n = 1'b0;
      #20;
      chk(allq === {NOUT{1'b1}}, "R9 outputs float in mid-run reset", int'(allq), 32'h7fff);
      release_and_align();

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule